// File: doc/BRIEF.md
# Two-Wire Register-Port Slave

This block is the serial front end of a 64-byte register space. It follows a two-wire bus (SCL, SDA) by sampling both lines with the fast system clock. It answers one fixed 7-bit device address and turns bus transfers into single-cycle accesses on a plain register port (address, write data, write strobe, combinational read data). The register space holds a calendar/clock window at locations 00h to 07h, followed by control, watchdog, alarm and square-wave registers and general RAM. The block only sees the space as 64 byte locations.

A persistent word pointer selects the location. A write transfer first loads the pointer and then stores bytes at it. A read transfer returns bytes from the pointer. A read may follow a repeated START, which gives a random read, or it may stand alone, which gives a current-address read. The pointer moves only on an acknowledge clock that follows a data byte. While an addressed transfer has the pointer inside the clock window, the `clk_hold` output tells the time-keeping logic to freeze its user-visible copy.

The controller has these states. ST_IDLE waits for a START. ST_DEVADR receives the device byte. ST_DEVACK acknowledges it. ST_PTRBYTE and ST_PTRACK receive and acknowledge the word address. ST_WRBYTE and ST_WRACK receive, store and acknowledge data. ST_RDBYTE shifts a byte out. ST_RDACK samples the master's acknowledge. ST_PARK holds SDA released until the next START or STOP. The transitions are:
- START from any state goes to ST_DEVADR, and STOP from any state goes to ST_IDLE.
- ST_DEVADR goes to ST_DEVACK on a match, or to ST_PARK on a mismatch.
- ST_DEVACK goes to ST_PTRBYTE for a write, or to ST_RDBYTE for a read.
- ST_PTRBYTE goes to ST_PTRACK, then to ST_WRBYTE.
- ST_WRBYTE and ST_WRACK alternate.
- ST_RDBYTE goes to ST_RDACK. ST_RDACK goes back to ST_RDBYTE on an acknowledge, or to ST_PARK on a not-acknowledge.

Top module: `i2c_regport_slave`

## Requirements
- R1: The block acknowledges only the device byte 1101000 followed by the R/W bit (D0h for write, D1h for read). Any other device byte gets no acknowledge, and the rest of that transfer changes neither the registers nor the pointer.
- R2: In a write transfer, the first byte after the device byte is acknowledged and loads its low 6 bits into the word pointer.
- R3: Each further write byte is acknowledged and stored at the pointer by one single-cycle `reg_we` pulse.
- R4: The pointer advances by one on the acknowledge clock of each data byte, in both writes and reads. Loading the word address does not advance it.
- R5: After a word-address write, a repeated START and the device byte with R/W=1, read data starts at the loaded address and continues at successive addresses.
- R6: A read with no preceding address write starts at the address last held in the pointer, which persists across transfers.
- R7: The pointer wraps from 3Fh to 00h.
- R8: After the master does not acknowledge a read byte, SDA stays released until the next START. The pointer does not advance on that byte.
- R9: `clk_hold` is high while a transfer addressed to this block is open and the pointer is below 08h. It falls on STOP, or as soon as the pointer reaches 08h or above.
- R10: START and STOP are detected from the synchronised lines: SDA falling or rising while SCL is high. Either one, seen in the middle of a byte, abandons that byte with no register write. A START then begins a new device byte.
- R11: After reset, SDA is released, `reg_we` and `clk_hold` are low, and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | ADDR_W (6) | Register location, equal to the word pointer |
| reg_wdata | output | 8 | Byte to store |
| reg_we | output | 1 | One-cycle store strobe |
| reg_rdata | input | 8 | Combinational read data for `reg_addr` |
| clk_hold | output | 1 | Freeze request for the clock window |

## Verification
The bench uses the default parameters: device address 68h, a 6-bit pointer (64 locations), a clock window of 8 and two synchroniser stages. A bus quarter-period is 8 system clocks. The 6-bit pointer makes the 3Fh-to-00h wrap reachable in a three-byte transfer. The 8-entry window lets a two-byte write starting at 06h cross out of the window in the middle of a transfer. The quarter-period leaves enough cycles after each SCL edge for the slave's SDA change to settle before the next sample, so near-miss device addresses, aborted bytes, NACKed reads and random write/read-back runs are all checked at the bus pins.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_PTRBYTE,
        ST_PTRACK,
        ST_WRBYTE,
        ST_WRACK,
        ST_RDBYTE,
        ST_RDACK,
        ST_PARK
    } rp_state_t;

endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    // Synchroniser chains for both bus lines, followed by one history flop each.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[STAGES-2:0], sda_i};
            scl_q     <= scl_s;
            sda_q     <= sda_s;
        end
    end

    assign scl_s     = scl_chain[STAGES-1];
    assign sda_s     = sda_chain[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rp_ptr.sv
module i2c_rp_ptr #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned WIN    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    input  logic              claim,
    input  logic              stop_det,
    output logic [ADDR_W-1:0] ptr,
    output logic              hold
);

    localparam logic [ADDR_W-1:0] WIN_L = ADDR_W'(WIN);
    localparam logic [ADDR_W-1:0] TOP_L = '1;

    logic [ADDR_W-1:0] ptr_q;
    logic              open_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_val;
        end else if (inc) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    // An addressed transfer stays open from the device-byte match until STOP.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (stop_det) begin
            open_q <= 1'b0;
        end else if (claim) begin
            open_q <= 1'b1;
        end
    end

    assign ptr  = ptr_q;
    assign hold = open_q & (ptr_q < WIN_L);

    assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && ptr_q == TOP_L) |=> (ptr_q == '0));

    assert_hold_drop_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !hold);

    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (ptr_q == $past(ptr_q) + 1'b1));

endmodule

// File: rtl/i2c_rp_fsm.sv
module i2c_rp_fsm
    import i2c_rp_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h68,
    parameter int unsigned ADDR_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rdata,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              ptr_load,
    output logic [ADDR_W-1:0] ptr_load_val,
    output logic              ptr_inc,
    output logic              claim
);

    localparam logic [3:0] RX_DONE = 4'd8;
    localparam logic [3:0] TX_LAST = 4'd7;

    rp_state_t         state_q, state_n;
    logic [3:0]        bitcnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] wdat_q;
    logic              rw_q;
    logic              acked_q;
    logic              oe_q;
    logic              we_q;
    logic              byte_end;
    logic              dev_match;

    assign byte_end  = scl_fall && (bitcnt_q == RX_DONE);
    assign dev_match = (shreg_q[7:1] == DEV_ADDR);

    // Next-state logic
    always_comb begin
        state_n = state_q;
        if (start_det) begin
            state_n = ST_DEVADR;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_n = ST_IDLE;
                ST_PARK:    state_n = ST_PARK;
                ST_DEVADR:  if (byte_end) state_n = dev_match ? ST_DEVACK : ST_PARK;
                ST_DEVACK:  if (scl_fall) state_n = rw_q ? ST_RDBYTE : ST_PTRBYTE;
                ST_PTRBYTE: if (byte_end) state_n = ST_PTRACK;
                ST_PTRACK:  if (scl_fall) state_n = ST_WRBYTE;
                ST_WRBYTE:  if (byte_end) state_n = ST_WRACK;
                ST_WRACK:   if (scl_fall) state_n = ST_WRBYTE;
                ST_RDBYTE:  if (scl_fall && bitcnt_q == TX_LAST) state_n = ST_RDACK;
                ST_RDACK:   if (scl_fall) state_n = acked_q ? ST_RDBYTE : ST_PARK;
                default:    state_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            shreg_q  <= '0;
            wdat_q   <= '0;
            rw_q     <= 1'b0;
            acked_q  <= 1'b0;
            oe_q     <= 1'b0;
            we_q     <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (start_det || stop_det) begin
                bitcnt_q <= '0;
                oe_q     <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_DEVADR, ST_PTRBYTE, ST_WRBYTE: begin
                        if (scl_rise) begin
                            shreg_q  <= {shreg_q[BYTE_W-2:0], sda_s};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end
                        if (byte_end) begin
                            bitcnt_q <= '0;
                            if (state_q == ST_DEVADR) begin
                                rw_q <= shreg_q[0];
                                oe_q <= dev_match;
                            end else begin
                                oe_q <= 1'b1;
                            end
                            if (state_q == ST_WRBYTE) begin
                                we_q   <= 1'b1;
                                wdat_q <= shreg_q;
                            end
                        end
                    end
                    ST_DEVACK: begin
                        if (scl_fall) begin
                            bitcnt_q <= '0;
                            if (rw_q) begin
                                shreg_q <= rdata;
                                oe_q    <= ~rdata[BYTE_W-1];
                            end else begin
                                oe_q <= 1'b0;
                            end
                        end
                    end
                    ST_PTRACK, ST_WRACK: begin
                        if (scl_fall) oe_q <= 1'b0;
                    end
                    ST_RDBYTE: begin
                        if (scl_fall) begin
                            if (bitcnt_q == TX_LAST) begin
                                oe_q <= 1'b0;
                            end else begin
                                shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
                                oe_q     <= ~shreg_q[BYTE_W-2];
                                bitcnt_q <= bitcnt_q + 1'b1;
                            end
                        end
                    end
                    ST_RDACK: begin
                        if (scl_rise) acked_q <= ~sda_s;
                        if (scl_fall && acked_q) begin
                            bitcnt_q <= '0;
                            shreg_q  <= rdata;
                            oe_q     <= ~rdata[BYTE_W-1];
                        end
                    end
                    ST_IDLE, ST_PARK: oe_q <= 1'b0;
                    default:          oe_q <= 1'b0;
                endcase
            end
        end
    end

    assign sda_oe       = oe_q;
    assign wr_en        = we_q;
    assign wr_data      = wdat_q;
    assign ptr_load     = (state_q == ST_PTRBYTE) && byte_end;
    assign ptr_load_val = shreg_q[ADDR_W-1:0];
    assign ptr_inc      = scl_rise && ((state_q == ST_WRACK) ||
                                       (state_q == ST_RDACK && !sda_s));
    assign claim        = (state_q == ST_DEVADR) && byte_end && dev_match;

    assert_we_in_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> (state_q == ST_WRACK && oe_q));

    assert_we_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |=> !we_q);

    assert_inc_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && state_q == ST_WRACK) |-> oe_q);

    assert_park_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARK || state_q == ST_IDLE) |-> !oe_q);

    assert_start_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_DEVADR && !oe_q && !we_q));

endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
    import i2c_rp_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h68,
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned CLK_WIN     = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              clk_hold
);

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              ptr_load, ptr_inc, claim;
    logic [ADDR_W-1:0] ptr_load_val, ptr;

    i2c_rp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rp_fsm #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .rdata        (reg_rdata),
        .sda_oe       (sda_oe),
        .wr_en        (reg_we),
        .wr_data      (reg_wdata),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .ptr_inc      (ptr_inc),
        .claim        (claim)
    );

    i2c_rp_ptr #(.ADDR_W(ADDR_W), .WIN(CLK_WIN)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ptr_load_val),
        .inc      (ptr_inc),
        .claim    (claim),
        .stop_det (stop_det),
        .ptr      (ptr),
        .hold     (clk_hold)
    );

    assign reg_addr = ptr;

endmodule

// File: tb/sim_i2c_regport_slave.sv
module sim_i2c_regport_slave;

    localparam int QC = 8;   // system clocks per bus quarter-period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    logic       clk_hold;
    logic       sda_bus;

    logic [7:0] rf      [64];
    logic [7:0] exp_mem [64];
    logic [5:0] exp_ptr = 6'd0;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = rf[reg_addr];

    always @(posedge clk) if (reg_we) rf[reg_addr] <= reg_wdata;

    i2c_regport_slave u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .clk_hold  (clk_hold)
    );

    function automatic logic [5:0] ptr_next(input logic [5:0] p);
        return p + 6'd1;
    endfunction

    function automatic logic [7:0] seed_val(input int i);
        return 8'((i * 37 + 11) ^ 8'h5A);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n * QC) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wait_q(1);
        scl_m = 1'b1; wait_q(2);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b1; wait_q(1);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        ack = ~sda_bus; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q(1);
            scl_m = 1'b1; wait_q(1);
            d[i] = sda_bus; wait_q(1);
            scl_m = 1'b0; wait_q(1);
        end
        bit_out(~mack);
    endtask

    task automatic do_write(input logic [5:0] a, input int n);
        logic ack;
        logic [7:0] d;
        bus_start;
        send_byte(8'hD0, ack); chk(ack, "R1 write device ack", ack, 1);
        send_byte({2'b00, a}, ack); chk(ack, "R2 word address ack", ack, 1);
        exp_ptr = a;
        if (a < 6'd8) chk(clk_hold == 1'b1, "R9 hold inside window", clk_hold, 1);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, ack); chk(ack, "R3 data byte ack", ack, 1);
            exp_mem[exp_ptr] = d;
            exp_ptr = ptr_next(exp_ptr);
        end
        bus_stop;
        chk(clk_hold == 1'b0, "R9 hold cleared by STOP", clk_hold, 0);
    endtask

    task automatic do_read(input bit set_addr, input logic [5:0] a, input int n, input string tag);
        logic ack;
        logic [7:0] d;
        bus_start;
        if (set_addr) begin
            send_byte(8'hD0, ack); chk(ack, "R5 device ack before repeat", ack, 1);
            send_byte({2'b00, a}, ack); chk(ack, "R2 word address ack", ack, 1);
            exp_ptr = a;
            bus_start;
        end
        send_byte(8'hD1, ack); chk(ack, "R1 read device ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            chk(d == exp_mem[exp_ptr], tag, d, exp_mem[exp_ptr]);
            if (k < n - 1) exp_ptr = ptr_next(exp_ptr);
        end
        bus_stop;
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        logic [5:0] ra;
        int rn;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin
            rf[i] = seed_val(i);
            exp_mem[i] = seed_val(i);
        end
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11: reset state at the ports
        chk(sda_oe == 1'b0, "R11 SDA released", sda_oe, 0);
        chk(reg_we == 1'b0, "R11 no write strobe", reg_we, 0);
        chk(clk_hold == 1'b0, "R11 hold low", clk_hold, 0);
        // R11: pointer starts at 00h (current-address read)
        exp_ptr = 6'd0;
        do_read(1'b0, 6'd0, 1, "R11 pointer at 00h after reset");

        // R1: near-miss device address, no ack and no effect
        do_read(1'b1, 6'h10, 1, "R5 random read 10h");
        bus_start;
        send_byte(8'hD2, ack); chk(ack == 1'b0, "R1 foreign address not acked", ack, 0);
        send_byte(8'h05, ack); chk(ack == 1'b0, "R1 foreign word not acked", ack, 0);
        send_byte(8'h77, ack); chk(ack == 1'b0, "R1 foreign data not acked", ack, 0);
        chk(clk_hold == 1'b0, "R9 no hold for foreign transfer", clk_hold, 0);
        bus_stop;
        do_read(1'b0, 6'd0, 1, "R1 foreign transfer left pointer and data");

        // R8: master NACK releases SDA, pointer stays
        bus_start;
        send_byte(8'hD0, ack);
        send_byte(8'h12, ack);
        exp_ptr = 6'h12;
        bus_start;
        send_byte(8'hD1, ack);
        recv_byte(1'b0, d); chk(d == exp_mem[6'h12], "R5 read after repeat", d, exp_mem[6'h12]);
        recv_byte(1'b0, d); chk(d == 8'hFF, "R8 bus released after NACK", d, 8'hFF);
        bus_stop;
        do_read(1'b0, 6'd0, 1, "R8 pointer not advanced by NACKed byte");

        // R9: pointer leaves the clock window mid-transfer
        bus_start;
        send_byte(8'hD0, ack);
        send_byte(8'h06, ack); exp_ptr = 6'h06;
        chk(clk_hold == 1'b1, "R9 hold at 06h", clk_hold, 1);
        d = 8'hA5; send_byte(d, ack); exp_mem[6'h06] = d;
        chk(clk_hold == 1'b1, "R9 hold at 07h", clk_hold, 1);
        d = 8'h3C; send_byte(d, ack); exp_mem[6'h07] = d;
        chk(clk_hold == 1'b0, "R9 hold dropped at 08h", clk_hold, 0);
        bus_stop;
        exp_ptr = 6'h08;
        do_read(1'b1, 6'h06, 2, "R4 read back across window edge");

        // R10: STOP in mid-byte aborts
        bus_start;
        send_byte(8'hD0, ack);
        send_byte(8'h20, ack);
        for (int i = 0; i < 5; i++) bit_out(1'b0);
        bus_stop;
        do_read(1'b1, 6'h20, 1, "R10 STOP mid-byte wrote nothing");

        // R10: repeated START in mid-byte aborts and restarts
        bus_start;
        send_byte(8'hD0, ack);
        send_byte(8'h21, ack);
        for (int i = 0; i < 3; i++) bit_out(1'b1);
        bus_start;
        send_byte(8'hD0, ack); chk(ack, "R10 device byte after mid-byte START", ack, 1);
        bus_stop;
        do_read(1'b1, 6'h21, 1, "R10 START mid-byte wrote nothing");

        // R7: wrap from 3Fh to 00h
        do_write(6'h3E, 3);
        do_read(1'b1, 6'h3E, 3, "R7 wrap 3Fh to 00h");

        // R3 R4 R5 R6: constrained random writes and reads
        for (int it = 0; it < 8; it++) begin
            ra = 6'($urandom_range(0, 63));
            rn = int'($urandom_range(1, 4));
            do_write(ra, rn);
            do_read(1'b1, ra, rn, "R5 random read back");
            do_read(1'b0, 6'd0, 2, "R6 current-address read");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (R1) actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule